// File: doc/BRIEF.md
# SDRAM Bank Command Legality Checker

This block sits beside the command bus of a four-bank SDRAM and watches each command the device registers. It decodes the chip select, row strobe, column strobe and write enable lines, together with the bank address and the auto precharge address bit. It follows every bank through a small state machine. Row open, precharge and burst periods are counted in clock cycles from module parameters. Any command that the addressed bank's state forbids, or that the global state forbids, produces a one-cycle error pulse and a code that names the command and the bank.

The monitor changes nothing on the bus. An illegal command leaves all tracked state as it was, so later commands are judged against the state the device really holds. Some rules involve more than one bank: refresh and mode-register commands need every bank to be idle, a burst stop acts only on the bank that owns the running burst, and a new column command cuts short a burst on another bank.

Top module: `sdram_cmd_checker`

## Requirements
- R1: After synchronous reset every bank reports idle (state code 0) and `err_o` is low.
- R2: Bank state codes are 0 idle, 1 opening, 2 open, 3 closing, 4 read, 5 write, 6 read with auto precharge, 7 write with auto precharge. ACTIVE to an idle bank shows 1 in the next cycle and 2 once T_RCD cycles have passed after the command cycle. ACTIVE to a non-idle bank is illegal, and so are READ and WRITE to an opening bank.
- R3: READ or WRITE with A10 low to an open bank (or to a bank in a plain burst) shows code 4 or 5 for BURST_LEN cycles and then 2. With A10 high it shows 6 or 7 for BURST_LEN+T_RP cycles and then 0.
- R4: PRECHARGE with A10 low closes the addressed bank. With A10 high it closes every bank and ignores the bank address. A closed bank shows 3 and returns to 0 T_RP cycles after the command. PRECHARGE is legal only on idle, open, read or write banks (idle ones stay idle). A precharge-all is illegal if any bank forbids it.
- R5: AUTO REFRESH and LOAD MODE REGISTER, and self refresh entry (AUTO REFRESH in a cycle where CKE falls), are legal only when all banks are idle. A refused entry does not enter self refresh.
- R6: BURST TERMINATE returns the bank in state 4 or 5 to state 2, whatever the bank address. It is illegal when no bank is in state 4 or 5, including while a bank is in state 6 or 7.
- R7: A command to bank m is judged only by bank m's state. A legal READ or WRITE to bank m moves another bank in state 4 or 5 to 2, and another bank in state 6 or 7 to 3 (idle T_RP cycles later).
- R8: Commands are checked and acted on only when CKE was high in the previous cycle and is high now. At other times they raise no error and change no state.
- R9: The first cycle with CKE high after self refresh is the exit cycle. In the T_XSR-1 cycles after it, any command other than NOP raises an error. A command T_XSR cycles after the exit cycle is judged normally.
- R10: Commands decode from {CS#,RAS#,CAS#,WE#}: ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, BURST TERMINATE 0110, AUTO REFRESH 0001, LOAD MODE 0000, NOP 0111. CS# high is an inhibit and never errs. An illegal command raises `err_o` for exactly the next cycle, with `err_code` = {RAS#,CAS#,WE#} in bits 4:2 and the bank address in bits 1:0. The illegal command leaves all bank states unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable seen by the device |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto precharge / all-banks address bit |
| bank_state | output | 12 | Bank i state code in bits 3i+2:3i |
| err_o | output | 1 | One-cycle pulse after an illegal command |
| err_code | output | 5 | Offending command and bank |

## Verification
The legality function is driven with the same command sent to banks in different states. This separates a decision made from the addressed bank's state from one made from another bank's state, as in column commands to an opening, open or idle bank. Global commands are sent both with one bank open and with all banks idle, which shows that the all-idle gate is real. Burst stop is tried with the bank address pointing away from the burst owner, with no owner, and with only an auto-precharge burst running. This shows that it acts on the owner alone. CKE patterns (low now, low only in the previous cycle, a self refresh exit) show when checking is suspended, and the exit window is probed at its last blocked cycle and at its first free cycle.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [2:0] {
        CMD_LMR  = 3'b000,
        CMD_AREF = 3'b001,
        CMD_PRE  = 3'b010,
        CMD_ACT  = 3'b011,
        CMD_WR   = 3'b100,
        CMD_RD   = 3'b101,
        CMD_BST  = 3'b110,
        CMD_NOP  = 3'b111
    } cmd_e;

    typedef enum logic [2:0] {
        BS_IDLE    = 3'd0,
        BS_OPENING = 3'd1,
        BS_OPEN    = 3'd2,
        BS_CLOSING = 3'd3,
        BS_RD      = 3'd4,
        BS_WR      = 3'd5,
        BS_RD_AP   = 3'd6,
        BS_WR_AP   = 3'd7
    } bank_st_e;

    typedef struct packed {
        logic sel;
        cmd_e op;
    } bus_cmd_t;

    localparam int ST_W = 3;

    function automatic logic pre_ok(bank_st_e s);
        return (s == BS_IDLE) || (s == BS_OPEN) || (s == BS_RD) || (s == BS_WR);
    endfunction

    function automatic logic col_ok(bank_st_e s);
        return (s == BS_OPEN) || (s == BS_RD) || (s == BS_WR);
    endfunction

    function automatic logic is_col(cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_chk_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output bus_cmd_t cmd
);
    always_comb begin
        cmd.sel = ~cs_n;
        cmd.op  = cmd_e'({ras_n, cas_n, we_n});
    end
endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_chk_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int BURST_LEN = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     open_i,
    input  logic     col_i,
    input  logic     col_wr_i,
    input  logic     col_ap_i,
    input  logic     close_i,
    input  logic     stop_i,
    input  logic     cut_i,
    output bank_st_e state_o
);
    localparam int CW = $clog2(BURST_LEN + T_RP + T_RCD + 1);
    localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] LD_BL  = CW'(BURST_LEN - 1);
    localparam logic [CW-1:0] LD_AP  = CW'(BURST_LEN + T_RP - 1);

    bank_st_e        st;
    logic [CW-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= BS_IDLE;
            cnt <= '0;
        end else if (open_i) begin
            st  <= BS_OPENING;
            cnt <= LD_RCD;
        end else if (col_i) begin
            if (col_ap_i) begin
                st  <= col_wr_i ? BS_WR_AP : BS_RD_AP;
                cnt <= LD_AP;
            end else begin
                st  <= col_wr_i ? BS_WR : BS_RD;
                cnt <= LD_BL;
            end
        end else if ((close_i && st != BS_IDLE) || cut_i) begin
            st  <= BS_CLOSING;
            cnt <= LD_RP;
        end else if (stop_i) begin
            st  <= BS_OPEN;
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
                case (st)
                    BS_OPENING, BS_RD, BS_WR:        st <= BS_OPEN;
                    BS_CLOSING, BS_RD_AP, BS_WR_AP:  st <= BS_IDLE;
                    default:                         st <= st;
                endcase
            end
        end
    end

    assign state_o = st;
endmodule

// File: rtl/sdram_sref_track.sv
module sdram_sref_track #(
    parameter int T_XSR = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic enter_i,
    output logic busy_o
);
    localparam int XW = $clog2(T_XSR + 1);

    logic          in_sr;
    logic [XW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_sr <= 1'b0;
            cnt   <= '0;
        end else if (enter_i) begin
            in_sr <= 1'b1;
        end else if (in_sr && cke) begin
            in_sr <= 1'b0;
            cnt   <= XW'(T_XSR - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy_o = (cnt != '0);
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int BURST_LEN = 4,
    parameter int T_XSR     = 6,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cke,
    input  logic                      cs_n,
    input  logic                      ras_n,
    input  logic                      cas_n,
    input  logic                      we_n,
    input  logic [BA_W-1:0]           ba,
    input  logic                      a10,
    output logic [NUM_BANKS*ST_W-1:0] bank_state,
    output logic                      err_o,
    output logic [2+BA_W:0]           err_code
);
    logic                 cke_q;
    bus_cmd_t             cmd;
    bank_st_e             st [NUM_BANKS];
    logic [NUM_BANKS-1:0] owner;
    logic                 all_idle, pre_all_ok, any_owner;
    logic                 xsr_busy, chk, sr_try, bad, ok;
    bank_st_e             tgt;

    sdram_cmd_decode u_dec (
        .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
    );

    always_ff @(posedge clk) begin
        if (rst) cke_q <= 1'b0;
        else     cke_q <= cke;
    end

    assign chk       = cke_q & cke & cmd.sel;
    assign sr_try    = cke_q & ~cke & cmd.sel & (cmd.op == CMD_AREF);
    assign tgt       = st[ba];
    assign any_owner = |owner;

    always_comb begin
        all_idle   = 1'b1;
        pre_all_ok = 1'b1;
        for (int i = 0; i < NUM_BANKS; i++) begin
            all_idle   &= (st[i] == BS_IDLE);
            pre_all_ok &= pre_ok(st[i]);
        end
    end

    always_comb begin
        bad = 1'b0;
        if (sr_try) begin
            bad = ~all_idle;
        end else if (chk) begin
            if (xsr_busy && cmd.op != CMD_NOP) begin
                bad = 1'b1;
            end else begin
                case (cmd.op)
                    CMD_ACT:           bad = (tgt != BS_IDLE);
                    CMD_RD, CMD_WR:    bad = ~col_ok(tgt);
                    CMD_PRE:           bad = a10 ? ~pre_all_ok : ~pre_ok(tgt);
                    CMD_BST:           bad = ~any_owner;
                    CMD_AREF, CMD_LMR: bad = ~all_idle;
                    default:           bad = 1'b0;
                endcase
            end
        end
    end

    assign ok = chk & ~bad;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic hit, col_cmd;
        assign hit      = (ba == BA_W'(i));
        assign col_cmd  = is_col(cmd.op);
        assign owner[i] = (st[i] == BS_RD) || (st[i] == BS_WR);

        sdram_bank_fsm #(
            .T_RCD(T_RCD), .T_RP(T_RP), .BURST_LEN(BURST_LEN)
        ) u_fsm (
            .clk     (clk),
            .rst     (rst),
            .open_i  (ok && cmd.op == CMD_ACT && hit),
            .col_i   (ok && col_cmd && hit),
            .col_wr_i(cmd.op == CMD_WR),
            .col_ap_i(a10),
            .close_i (ok && cmd.op == CMD_PRE && (a10 || hit)),
            .stop_i  (ok && owner[i] && (cmd.op == CMD_BST || (col_cmd && !hit))),
            .cut_i   (ok && col_cmd && !hit &&
                      (st[i] == BS_RD_AP || st[i] == BS_WR_AP)),
            .state_o (st[i])
        );

        assign bank_state[ST_W*i +: ST_W] = st[i];
    end

    sdram_sref_track #(.T_XSR(T_XSR)) u_sref (
        .clk    (clk),
        .rst    (rst),
        .cke    (cke),
        .enter_i(sr_try & ~bad),
        .busy_o (xsr_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_o    <= 1'b0;
            err_code <= '0;
        end else begin
            err_o    <= bad;
            err_code <= {cmd.op, ba};
        end
    end
endmodule

// File: rtl/sdram_cmd_checker_sva.sv
module sdram_cmd_checker_sva #(
    parameter int NUM_BANKS = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cke,
    input logic                   cke_q,
    input logic                   cs_n,
    input logic                   ras_n,
    input logic                   cas_n,
    input logic                   we_n,
    input logic [BA_W-1:0]        ba,
    input logic [NUM_BANKS*3-1:0] bank_state,
    input logic                   err_o
);
    logic [2:0]           op;
    logic [2:0]           tgt;
    logic                 live;
    logic [NUM_BANKS-1:0] owner;

    assign op   = {ras_n, cas_n, we_n};
    assign live = cke_q & cke & ~cs_n;
    assign tgt  = bank_state[ba*3 +: 3];

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_b
        assign owner[i] = (bank_state[3*i +: 3] == 3'd4) || (bank_state[3*i +: 3] == 3'd5);

        p_close_exit_r4: assert property (@(posedge clk) disable iff (rst)
            (bank_state[3*i +: 3] == 3'd3) |=>
                (bank_state[3*i +: 3] == 3'd3 || bank_state[3*i +: 3] == 3'd0));
    end

    p_inhibit_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !err_o);

    p_global_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (live && (op == 3'b001 || op == 3'b000) && bank_state != '0) |=> err_o);

    p_act_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (live && op == 3'b011 && tgt != 3'd0) |=> err_o);

    p_unchecked_r8: assert property (@(posedge clk) disable iff (rst)
        (!cke_q && cke) |=> !err_o);

    p_bst_orphan_r6: assert property (@(posedge clk) disable iff (rst)
        (live && op == 3'b110 && owner == '0) |=> err_o);

    p_single_burst_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(owner) <= 1);
endmodule

bind sdram_cmd_checker sdram_cmd_checker_sva #(.NUM_BANKS(NUM_BANKS)) u_sva (
    .clk(clk), .rst(rst), .cke(cke), .cke_q(cke_q), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
    .bank_state(bank_state), .err_o(err_o)
);

// File: tb/test_sdram_cmd_checker.sv
module test_sdram_cmd_checker;
    localparam int TRCD = 3;
    localparam int TRP  = 3;
    localparam int BL   = 4;
    localparam int TXSR = 6;

    localparam logic [2:0] OP_LMR = 3'b000, OP_AREF = 3'b001, OP_PRE = 3'b010,
                           OP_ACT = 3'b011, OP_WR = 3'b100, OP_RD = 3'b101,
                           OP_BST = 3'b110, OP_NOP = 3'b111;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic        a10 = 1'b0;
    logic [11:0] bank_state;
    logic        err_o;
    logic [4:0]  err_code;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sdram_cmd_checker #(
        .NUM_BANKS(4), .T_RCD(TRCD), .T_RP(TRP), .BURST_LEN(BL), .T_XSR(TXSR)
    ) i_sdram_cmd_checker (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
        .bank_state(bank_state), .err_o(err_o), .err_code(err_code)
    );

    task automatic issue(input logic [2:0] op, input logic [1:0] b, input logic ap);
        cs_n = 1'b0;
        {ras_n, cas_n, we_n} = op;
        ba  = b;
        a10 = ap;
        @(negedge clk);
        {ras_n, cas_n, we_n} = OP_NOP;
        a10 = 1'b0;
    endtask

    task automatic nop(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_st(input int b, input logic [2:0] exp, input string req);
        logic [2:0] act;
        act = bank_state[3*b +: 3];
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s bank%0d state: actual=%0d expected=%0d", req, b, act, exp);
        end
    endtask

    task automatic check_err(input logic exp, input string req);
        checks++;
        if (err_o !== exp) begin
            fails++;
            $display("FAIL %s err_o: actual=%0b expected=%0b", req, err_o, exp);
        end
    endtask

    task automatic check_code(input logic [4:0] exp, input string req);
        check_err(1'b1, req);
        checks++;
        if (err_code !== exp) begin
            fails++;
            $display("FAIL %s err_code: actual=%b expected=%b", req, err_code, exp);
        end
    endtask

    task automatic t_reset;
        for (int b = 0; b < 4; b++) check_st(b, 3'd0, "R1");
        check_err(1'b0, "R1");
    endtask

    task automatic t_activate;
        issue(OP_ACT, 2'd0, 1'b0);
        check_st(0, 3'd1, "R2");
        issue(OP_RD, 2'd0, 1'b0);
        check_code({OP_RD, 2'd0}, "R2 R10");
        check_st(0, 3'd1, "R10");
        nop(TRCD - 2);
        check_err(1'b0, "R10");
        check_st(0, 3'd2, "R2");
    endtask

    task automatic t_burst;
        issue(OP_RD, 2'd0, 1'b0);
        check_st(0, 3'd4, "R3");
        nop(BL - 2);
        check_st(0, 3'd4, "R3");
        nop(1);
        check_st(0, 3'd2, "R3");
        issue(OP_WR, 2'd0, 1'b1);
        check_st(0, 3'd7, "R3");
        nop(BL + TRP - 2);
        check_st(0, 3'd7, "R3");
        nop(1);
        check_st(0, 3'd0, "R3");
    endtask

    task automatic t_precharge;
        issue(OP_ACT, 2'd1, 1'b0);
        issue(OP_ACT, 2'd2, 1'b0);
        nop(TRCD);
        check_st(1, 3'd2, "R4");
        issue(OP_PRE, 2'd3, 1'b1);
        check_err(1'b0, "R4");
        check_st(1, 3'd3, "R4");
        check_st(2, 3'd3, "R4");
        check_st(3, 3'd0, "R4");
        issue(OP_PRE, 2'd1, 1'b0);
        check_code({OP_PRE, 2'd1}, "R4");
        nop(TRP - 2);
        check_st(1, 3'd0, "R4");
        check_st(2, 3'd0, "R4");
        issue(OP_ACT, 2'd1, 1'b0);
        nop(TRCD);
        issue(OP_PRE, 2'd1, 1'b0);
        check_st(1, 3'd3, "R4");
        check_st(0, 3'd0, "R4");
        nop(TRP - 1);
        check_st(1, 3'd0, "R4");
        issue(OP_ACT, 2'd2, 1'b0);
        issue(OP_PRE, 2'd0, 1'b1);
        check_code({OP_PRE, 2'd0}, "R4");
        check_st(2, 3'd1, "R4");
        nop(TRCD);
        issue(OP_PRE, 2'd0, 1'b1);
        nop(TRP - 1);
        check_st(2, 3'd0, "R4");
    endtask

    task automatic t_global;
        issue(OP_ACT, 2'd3, 1'b0);
        issue(OP_AREF, 2'd3, 1'b0);
        check_code({OP_AREF, 2'd3}, "R5");
        issue(OP_LMR, 2'd3, 1'b0);
        check_code({OP_LMR, 2'd3}, "R5");
        nop(TRCD);
        issue(OP_PRE, 2'd3, 1'b0);
        nop(TRP - 1);
        check_st(3, 3'd0, "R5");
        issue(OP_AREF, 2'd0, 1'b0);
        check_err(1'b0, "R5");
        issue(OP_LMR, 2'd0, 1'b0);
        check_err(1'b0, "R5");
    endtask

    task automatic t_bst;
        issue(OP_ACT, 2'd0, 1'b0);
        issue(OP_ACT, 2'd1, 1'b0);
        nop(TRCD);
        issue(OP_RD, 2'd0, 1'b0);
        check_st(0, 3'd4, "R6");
        issue(OP_BST, 2'd1, 1'b0);
        check_err(1'b0, "R6");
        check_st(0, 3'd2, "R6");
        check_st(1, 3'd2, "R6");
        issue(OP_BST, 2'd1, 1'b0);
        check_code({OP_BST, 2'd1}, "R6");
        issue(OP_RD, 2'd1, 1'b1);
        check_st(1, 3'd6, "R6");
        check_st(0, 3'd2, "R6");
        issue(OP_BST, 2'd0, 1'b0);
        check_code({OP_BST, 2'd0}, "R6");
        check_st(1, 3'd6, "R6");
        nop(BL + TRP - 2);
        check_st(1, 3'd0, "R6");
        issue(OP_PRE, 2'd0, 1'b0);
        nop(TRP - 1);
    endtask

    task automatic t_cross;
        issue(OP_ACT, 2'd0, 1'b0);
        issue(OP_ACT, 2'd1, 1'b0);
        nop(TRCD);
        issue(OP_RD, 2'd0, 1'b0);
        issue(OP_WR, 2'd1, 1'b0);
        check_err(1'b0, "R7");
        check_st(0, 3'd2, "R7");
        check_st(1, 3'd5, "R7");
        issue(OP_RD, 2'd2, 1'b0);
        check_code({OP_RD, 2'd2}, "R7");
        check_st(1, 3'd5, "R7");
        check_st(2, 3'd0, "R7");
        issue(OP_RD, 2'd0, 1'b1);
        check_st(0, 3'd6, "R7");
        check_st(1, 3'd2, "R7");
        issue(OP_WR, 2'd1, 1'b0);
        check_st(0, 3'd3, "R7");
        check_st(1, 3'd5, "R7");
        nop(TRP - 1);
        check_st(0, 3'd0, "R7");
        nop(BL);
        issue(OP_PRE, 2'd0, 1'b1);
        nop(TRP - 1);
        check_st(1, 3'd0, "R7");
    endtask

    task automatic t_cke;
        cke = 1'b0;
        issue(OP_ACT, 2'd0, 1'b0);
        check_err(1'b0, "R8");
        check_st(0, 3'd0, "R8");
        cke = 1'b1;
        issue(OP_RD, 2'd0, 1'b0);
        check_err(1'b0, "R8");
        check_st(0, 3'd0, "R8");
        issue(OP_RD, 2'd0, 1'b0);
        check_code({OP_RD, 2'd0}, "R8");
    endtask

    task automatic t_sref;
        issue(OP_ACT, 2'd2, 1'b0);
        cke = 1'b0;
        issue(OP_AREF, 2'd2, 1'b0);
        check_code({OP_AREF, 2'd2}, "R5");
        check_st(2, 3'd1, "R5");
        cke = 1'b1;
        nop(TRCD);
        issue(OP_PRE, 2'd2, 1'b0);
        check_err(1'b0, "R5");
        check_st(2, 3'd3, "R5");
        nop(TRP - 1);
        check_st(2, 3'd0, "R5");
        cke = 1'b0;
        issue(OP_AREF, 2'd0, 1'b0);
        check_err(1'b0, "R9");
        nop(3);
        cke = 1'b1;
        nop(1);
        issue(OP_ACT, 2'd0, 1'b0);
        check_code({OP_ACT, 2'd0}, "R9");
        check_st(0, 3'd0, "R9");
        nop(TXSR - 3);
        check_err(1'b0, "R9");
        issue(OP_ACT, 2'd0, 1'b0);
        check_code({OP_ACT, 2'd0}, "R9");
        issue(OP_ACT, 2'd0, 1'b0);
        check_err(1'b0, "R9");
        check_st(0, 3'd1, "R9");
        nop(TRCD);
        issue(OP_PRE, 2'd0, 1'b0);
        nop(TRP - 1);
        check_st(0, 3'd0, "R9");
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        nop(2);
        t_activate();
        t_burst();
        t_precharge();
        t_global();
        t_bst();
        t_cross();
        t_cke();
        t_sref();
        nop(2);
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule